// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked working form and turns it into a 32-bit IEEE-754 single-precision word. The working form has a two-bit class (zero, finite number, infinity, NaN), a sign, a signed unbiased exponent, and a wide mantissa. The mantissa carries its leading one explicitly at the top bit, and a separate sticky bit stands for any nonzero bits lost earlier. An arithmetic unit places the packer at the end of its datapath. The unit supplies the current rounding mode and the underflow-trap enable with each value, and it receives the packed word together with overflow, underflow and inexact flags.

Finite numbers are biased and aligned. Normal results keep a 24-bit significand. Results whose biased exponent is zero or negative are shifted further right so that leading zeros appear in the fraction. The bits below the kept field become guard, round and sticky, and the value is rounded in the selected mode. A carry out of rounding raises the exponent of a normal result, or promotes a subnormal result to the smallest normal. An exponent that ends at 255 or above saturates, either to infinity or to the largest finite magnitude. NaNs keep the upper bits of their mantissa as payload.

The block is a two-stage pipeline. It accepts one value per cycle, and each result appears two clock edges after its input.

Top module: `ieee_single_pack`

## Requirements
- R1: A value of class zero (code 2'b00) produces the input sign in bit 31, all other bits 0, and all three flags clear.
- R2: A value of class infinity (code 2'b10) produces the sign, exponent field 255 and fraction 0, with all flags clear.
- R3: A value of class NaN (code 2'b11) produces exponent field 255 and a fraction equal to the mantissa bits just below its top bit (bits MANT_W-2 down to MANT_W-24), with all flags clear.
- R4: A finite value (code 2'b01) whose biased exponent e+127 lies in 1..254 and which needs no rounding is packed as {sign, e+127, the 23 mantissa bits below the leading one}, with no flags.
- R5: Rounding follows the mode code: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward plus infinity, 2'b11 toward minus infinity. The inexact flag is set exactly when any guard, round or sticky bit is nonzero.
- R6: When rounding a normal result carries out of the 24-bit significand, the exponent rises by one and the fraction becomes 0.
- R7: A finite value whose biased exponent b is 0 or below packs with exponent field 0, and its leading one lands 1-b places below the implied position.
- R8: A subnormal that rounds up to 2^23 is output as the smallest normal, exponent 1 and fraction 0, with the underflow flag clear.
- R9: A subnormal that stays subnormal sets the underflow flag if the result is inexact or if the trap-enable input is 1, and clears it otherwise.
- R10: A final biased exponent of 255 or more is an overflow. In mode nearest, in mode toward plus infinity with a positive sign, or in mode toward minus infinity with a negative sign, the output is infinity and the overflow flag is set. In every other case the output is exponent 254 with an all-ones fraction, and the overflow flag stays clear.
- R11: out_valid rises two clock edges after in_valid is sampled high, and reset clears out_valid and the output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input value present this cycle |
| in_class | input | 2 | 00 zero, 01 finite, 10 infinity, 11 NaN |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa with the leading one at the top bit |
| in_sticky | input | 1 | OR of bits already discarded below the mantissa |
| in_rmode | input | 2 | Rounding mode code |
| in_uf_trap | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Packed result present |
| out_word | output | 32 | IEEE-754 single-precision word |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The bench aims at the boundaries where a packer usually goes wrong.
- The significand of all ones with the guard bit set must carry into the exponent. A design that drops the carry returns a value half as large.
- The largest subnormal that rounds up must be promoted. A faulty design leaves exponent 0 or raises underflow.
- Exponent 128 and a carry from exponent 127 are driven in every mode and with both signs. A design with the wrong mode/sign table returns infinity where it should saturate, or the reverse.
- Ties are rounded to even, and tiny values are driven with only the sticky bit set, which exposes any rounding that ignores the sticky bit.
- The underflow trap bit is driven on exact subnormals. A design that ties underflow only to inexact misses it there.

// File: rtl/ieee_pack_pkg.sv
// Shared constants and codes for the single-precision packer.
// Assumes the destination format is IEEE-754 binary32.
package ieee_pack_pkg;
    localparam int FRAC_W  = 23;
    localparam int EXPF_W  = 8;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int BIAS_V  = (1 << (EXPF_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXPF_W) - 1;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NUM  = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } num_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;
endpackage

// File: rtl/ieee_pack_align.sv
// Biases the exponent and shifts the mantissa so that the kept significand
// sits in the low SIG_W+2 bits as {significand, guard, round}. Every bit
// shifted below them is folded into the sticky bit.
// Assumes MANT_W >= SIG_W + 2 and that a finite mantissa has its top bit set.
module ieee_pack_align
    import ieee_pack_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10
) (
    input  logic signed [EXP_W-1:0]  exp_in,
    input  logic [MANT_W-1:0]        mant_in,
    input  logic                     sticky_in,
    output logic signed [EXP_W+1:0]  biased_out,
    output logic                     subn_out,
    output logic [SIG_W+1:0]         grv_out,
    output logic                     sticky_out
);
    localparam int BE_W = EXP_W + 2;
    localparam int SH_W = BE_W + 1;
    localparam int NSH  = MANT_W - SIG_W - 2;
    localparam logic signed [BE_W-1:0] BIAS_S = BE_W'(BIAS_V);
    localparam logic signed [SH_W-1:0] NSH_S  = SH_W'(NSH);
    localparam logic signed [SH_W-1:0] CAP_S  = SH_W'(MANT_W);

    logic signed [BE_W-1:0] be;
    logic signed [SH_W-1:0] dsh_raw;
    logic [SH_W-1:0]        dsh;
    logic [MANT_W-1:0]      kept;
    logic [MANT_W-1:0]      lost_mask;

    // Biased exponent and the subnormal test
    always_comb begin
        be         = BE_W'(exp_in) + BIAS_S;
        biased_out = be;
        subn_out   = (be <= 0);
    end

    // Shift distance: fixed for normals, extra (1 - biased) for subnormals, capped
    always_comb begin
        dsh_raw = NSH_S;
        if (subn_out) begin
            dsh_raw = NSH_S + SH_W'(1) - SH_W'(be);
        end
        if (dsh_raw > CAP_S) begin
            dsh = SH_W'(MANT_W);
        end else begin
            dsh = dsh_raw;
        end
    end

    // Kept field and sticky collection from the bits shifted out
    always_comb begin
        kept = mant_in >> dsh;
        if (dsh >= SH_W'(MANT_W)) begin
            lost_mask = '1;
        end else begin
            lost_mask = (MANT_W'(1) << dsh) - MANT_W'(1);
        end
        grv_out    = kept[SIG_W+1:0];
        sticky_out = sticky_in | (|(mant_in & lost_mask));
    end
endmodule

// File: rtl/ieee_pack_round.sv
// Rounds {significand, guard, round} plus sticky in one of four modes.
// The result is one bit wider than the significand, so a carry out is kept.
// Assumes the mode codes of ieee_pack_pkg::rmode_e.
module ieee_pack_round
    import ieee_pack_pkg::*;
#(
    parameter int SW = SIG_W
) (
    input  logic [SW+1:0] grv_in,
    input  logic          sticky_in,
    input  logic          sign_in,
    input  logic [1:0]    mode_in,
    output logic [SW:0]   rounded_out,
    output logic          inexact_out
);
    logic guard_b;
    logic round_b;
    logic lsb_b;
    logic bump;

    // Split out the guard, round and LSB bits
    always_comb begin
        lsb_b       = grv_in[2];
        guard_b     = grv_in[1];
        round_b     = grv_in[0];
        inexact_out = guard_b | round_b | sticky_in;
    end

    // Decide whether to add one ulp
    always_comb begin
        unique case (rmode_e'(mode_in))
            RM_NEAREST: bump = guard_b & (round_b | sticky_in | lsb_b);
            RM_ZERO:    bump = 1'b0;
            RM_UP:      bump = ~sign_in & inexact_out;
            RM_DOWN:    bump = sign_in & inexact_out;
            default:    bump = 1'b0;
        endcase
    end

    // Add the increment with the carry kept
    always_comb begin
        rounded_out = {1'b0, grv_in[SW+1:2]} + (SW+1)'(bump);
    end
endmodule

// File: rtl/ieee_single_pack.sv
// Packs an unpacked class/sign/exponent/mantissa value into binary32.
// Stage 1 aligns and registers; stage 2 rounds, resolves carry, subnormal
// promotion and overflow, then registers the word and flags.
// Assumes in_mant has its top bit set for finite values.
module ieee_single_pack
    import ieee_pack_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_class,
    input  logic                in_sign,
    input  logic [EXP_W-1:0]    in_exp,
    input  logic [MANT_W-1:0]   in_mant,
    input  logic                in_sticky,
    input  logic [1:0]          in_rmode,
    input  logic                in_uf_trap,
    output logic                out_valid,
    output logic [31:0]         out_word,
    output logic                out_ovf,
    output logic                out_unf,
    output logic                out_inx
);
    localparam int BE_W = EXP_W + 2;
    localparam logic signed [BE_W-1:0] TOP_S = BE_W'(EXP_TOP);
    localparam logic [EXPF_W-1:0] EXP_ONES  = '1;
    localparam logic [EXPF_W-1:0] EXP_MAXF  = EXP_ONES - EXPF_W'(1);
    localparam logic [FRAC_W-1:0] FRAC_ONES = '1;

    // Stage 0 (combinational) alignment results
    logic signed [BE_W-1:0] a_be;
    logic                   a_subn;
    logic [SIG_W+1:0]       a_grv;
    logic                   a_sticky;

    // Stage 1 registers
    logic                   s1_valid;
    logic [1:0]             s1_class;
    logic                   s1_sign;
    logic signed [BE_W-1:0] s1_be;
    logic                   s1_subn;
    logic [SIG_W+1:0]       s1_grv;
    logic                   s1_sticky;
    logic [1:0]             s1_mode;
    logic                   s1_trap;
    logic [FRAC_W-1:0]      s1_nan_frac;

    // Stage 2 combinational results
    logic [SIG_W:0]         r_sig;
    logic                   r_inx;
    logic signed [BE_W-1:0] r_be;
    logic                   r_to_inf;
    logic [31:0]            p_word;
    logic                   p_ovf;
    logic                   p_unf;
    logic                   p_inx;

    ieee_pack_align #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_align (
        .exp_in     ($signed(in_exp)),
        .mant_in    (in_mant),
        .sticky_in  (in_sticky),
        .biased_out (a_be),
        .subn_out   (a_subn),
        .grv_out    (a_grv),
        .sticky_out (a_sticky)
    );

    // Capture the aligned value and its control inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid    <= 1'b0;
            s1_class    <= CLS_ZERO;
            s1_sign     <= 1'b0;
            s1_be       <= '0;
            s1_subn     <= 1'b0;
            s1_grv      <= '0;
            s1_sticky   <= 1'b0;
            s1_mode     <= RM_NEAREST;
            s1_trap     <= 1'b0;
            s1_nan_frac <= '0;
        end else begin
            s1_valid    <= in_valid;
            s1_class    <= in_class;
            s1_sign     <= in_sign;
            s1_be       <= a_be;
            s1_subn     <= a_subn;
            s1_grv      <= a_grv;
            s1_sticky   <= a_sticky;
            s1_mode     <= in_rmode;
            s1_trap     <= in_uf_trap;
            s1_nan_frac <= in_mant[MANT_W-2 -: FRAC_W];
        end
    end

    ieee_pack_round #(
        .SW (SIG_W)
    ) u_round (
        .grv_in      (s1_grv),
        .sticky_in   (s1_sticky),
        .sign_in     (s1_sign),
        .mode_in     (s1_mode),
        .rounded_out (r_sig),
        .inexact_out (r_inx)
    );

    // Exponent after a possible rounding carry, and overflow direction
    always_comb begin
        r_be = s1_be + BE_W'(r_sig[SIG_W]);
        unique case (rmode_e'(s1_mode))
            RM_NEAREST: r_to_inf = 1'b1;
            RM_ZERO:    r_to_inf = 1'b0;
            RM_UP:      r_to_inf = ~s1_sign;
            RM_DOWN:    r_to_inf = s1_sign;
            default:    r_to_inf = 1'b1;
        endcase
    end

    // Assemble the word and flags for each class
    always_comb begin
        p_word = {s1_sign, 31'd0};
        p_ovf  = 1'b0;
        p_unf  = 1'b0;
        p_inx  = 1'b0;
        unique case (num_class_e'(s1_class))
            CLS_ZERO: begin
                p_word = {s1_sign, 31'd0};
            end
            CLS_INF: begin
                p_word = {s1_sign, EXP_ONES, {FRAC_W{1'b0}}};
            end
            CLS_NAN: begin
                p_word = {s1_sign, EXP_ONES, s1_nan_frac};
            end
            CLS_NUM: begin
                p_inx = r_inx;
                if (s1_subn) begin
                    if (r_sig[SIG_W-1]) begin
                        p_word = {s1_sign, EXPF_W'(1), {FRAC_W{1'b0}}};
                    end else begin
                        p_word = {s1_sign, {EXPF_W{1'b0}}, r_sig[FRAC_W-1:0]};
                        p_unf  = r_inx | s1_trap;
                    end
                end else if (r_be >= TOP_S) begin
                    if (r_to_inf) begin
                        p_word = {s1_sign, EXP_ONES, {FRAC_W{1'b0}}};
                        p_ovf  = 1'b1;
                    end else begin
                        p_word = {s1_sign, EXP_MAXF, FRAC_ONES};
                    end
                end else begin
                    p_word = {s1_sign, r_be[EXPF_W-1:0], r_sig[FRAC_W-1:0]};
                end
            end
            default: p_word = {s1_sign, 31'd0};
        endcase
    end

    // Register the packed result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_ovf   <= 1'b0;
            out_unf   <= 1'b0;
            out_inx   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_word <= p_word;
                out_ovf  <= p_ovf;
                out_unf  <= p_unf;
                out_inx  <= p_inx;
            end
        end
    end
endmodule

// File: rtl/ieee_single_pack_chk.sv
// Temporal checks on the packer ports, bound into every instance.
module ieee_single_pack_chk #(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_class,
    input logic              in_sign,
    input logic              out_valid,
    input logic [31:0]       out_word,
    input logic              out_ovf,
    input logic              out_unf,
    input logic              out_inx
);
    // R11
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R1
    zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b00) |-> ##2
        (out_word[30:0] == 31'd0 && !out_ovf && !out_unf && !out_inx));

    // R2
    inf_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b10) |-> ##2
        (out_word[30:0] == 31'h7F80_0000 && !out_ovf && !out_unf && !out_inx));

    // R3
    nan_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'b11) |-> ##2
        (out_word[30:23] == 8'hFF && !out_ovf && !out_unf && !out_inx));

    // R4
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_word[31] == $past(in_sign, 2)));

    // R10
    ovf_to_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (out_word[30:0] == 31'h7F80_0000));

    // R9
    unf_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> (out_word[30:23] == 8'd0 && !out_ovf));
endmodule

bind ieee_single_pack ieee_single_pack_chk #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_sign   (in_sign),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf),
    .out_inx   (out_inx)
);

// File: tb/ieee_single_pack_bench.sv
// Scoreboard bench: the driver queues expected words from a bit-level model,
// the monitor compares each result as it leaves the packer.
module ieee_single_pack_bench;
    localparam int MANT_W = 32;
    localparam int EXP_W  = 10;

    typedef struct {
        logic [31:0] word;
        logic        ovf;
        logic        unf;
        logic        inx;
        string       tag;
    } exp_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [1:0]        in_class = 2'b00;
    logic              in_sign = 1'b0;
    logic [EXP_W-1:0]  in_exp = '0;
    logic [MANT_W-1:0] in_mant = '0;
    logic              in_sticky = 1'b0;
    logic [1:0]        in_rmode = 2'b00;
    logic              in_uf_trap = 1'b0;
    logic              out_valid;
    logic [31:0]       out_word;
    logic              out_ovf;
    logic              out_unf;
    logic              out_inx;

    exp_item_t sb_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ieee_single_pack #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_ieee_single_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_class   (in_class),
        .in_sign    (in_sign),
        .in_exp     (in_exp),
        .in_mant    (in_mant),
        .in_sticky  (in_sticky),
        .in_rmode   (in_rmode),
        .in_uf_trap (in_uf_trap),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .out_ovf    (out_ovf),
        .out_unf    (out_unf),
        .out_inx    (out_inx)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [34:0] act, input logic [34:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Bit-by-bit model of the requirements
    function automatic exp_item_t model(input logic [1:0] cls, input logic sg,
                                        input int e, input logic [31:0] m,
                                        input logic st, input logic [1:0] md,
                                        input logic trap, input string tag);
        exp_item_t it;
        int be, sh, eo;
        longint sig;
        bit g, r, s, up, inx, to_inf;
        it.word = {sg, 31'd0}; it.ovf = 0; it.unf = 0; it.inx = 0; it.tag = tag;
        if (cls == 2'b10) it.word = {sg, 8'hFF, 23'd0};
        else if (cls == 2'b11) it.word = {sg, 8'hFF, m[30:8]};
        else if (cls == 2'b01) begin
            be = e + 127;
            sh = (be <= 0) ? (9 - be) : 8;
            sig = 0; g = 0; r = 0; s = st;
            for (int i = 0; i < 32; i++) begin
                if (m[i]) begin
                    if (i >= sh) sig = sig | (longint'(1) << (i - sh));
                    else if (i == sh - 1) g = 1;
                    else if (i == sh - 2) r = 1;
                    else s = 1;
                end
            end
            inx = g | r | s;
            case (md)
                2'b00: up = g && (r || s || sig[0]);
                2'b01: up = 0;
                2'b10: up = !sg && inx;
                default: up = sg && inx;
            endcase
            sig = sig + (up ? 1 : 0);
            it.inx = inx;
            if (be <= 0) begin
                if (sig >= (longint'(1) << 23)) it.word = {sg, 8'd1, 23'd0};
                else begin
                    it.word = {sg, 8'd0, sig[22:0]};
                    it.unf = inx | trap;
                end
            end else begin
                eo = be + ((sig >= (longint'(1) << 24)) ? 1 : 0);
                if (eo >= 255) begin
                    to_inf = (md == 2'b00) || (md == 2'b10 && !sg) || (md == 2'b11 && sg);
                    it.word = to_inf ? {sg, 8'hFF, 23'd0} : {sg, 8'hFE, 23'h7FFFFF};
                    it.ovf = to_inf;
                end else begin
                    it.word = {sg, eo[7:0], sig[22:0]};
                end
            end
        end
        return it;
    endfunction

    task automatic send(input logic [1:0] cls, input logic sg, input int e,
                        input logic [31:0] m, input logic st, input logic [1:0] md,
                        input logic trap, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_class = cls; in_sign = sg; in_exp = EXP_W'(e);
        in_mant = m; in_sticky = st; in_rmode = md; in_uf_trap = trap;
        sb_q.push_back(model(cls, sg, e, m, st, md, trap, tag));
    endtask

    // Monitor: pop and compare each result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected out_valid", 35'(out_word), 35'd0);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check({out_ovf, out_unf, out_inx, out_word} == {it.ovf, it.unf, it.inx, it.word},
                          it.tag, "{ovf,unf,inx,word}",
                          {out_ovf, out_unf, out_inx, out_word}, {it.ovf, it.unf, it.inx, it.word});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid == 1'b0, "R11", "out_valid in reset", 35'(out_valid), 35'd0);
        check(out_word == 32'd0, "R11", "out_word in reset", 35'(out_word), 35'd0);
        rst_n = 1'b1;

        // R11 latency: result two edges after input
        send(2'b01, 0, 0, 32'h8000_0000, 0, 2'b00, 0, "R4");
        @(negedge clk); in_valid = 1'b0;
        check(out_valid == 1'b0, "R11", "valid one edge later", 35'(out_valid), 35'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R11", "valid two edges later", 35'(out_valid), 35'd1);

        // R1 zeros, R2 infinities, R3 NaN payload
        send(2'b00, 0, 5, 32'hFFFF_FFFF, 1, 2'b00, 1, "R1");
        send(2'b00, 1, 0, 32'h0, 0, 2'b11, 0, "R1");
        send(2'b10, 0, 0, 32'h8000_0000, 1, 2'b01, 0, "R2");
        send(2'b10, 1, 0, 32'h8000_0000, 0, 2'b00, 0, "R2");
        send(2'b11, 0, 0, 32'hC000_1234, 0, 2'b00, 0, "R3");
        send(2'b11, 1, 0, 32'hFFFF_FF00, 1, 2'b10, 1, "R3");

        // R4 exact normals
        send(2'b01, 0, 0, 32'h8000_0000, 0, 2'b00, 0, "R4");
        send(2'b01, 1, -126, 32'hABCD_EF00, 0, 2'b10, 0, "R4");
        send(2'b01, 0, 127, 32'hFFFF_FF00, 0, 2'b11, 0, "R4");

        // R5 guard/round/sticky patterns in all modes and signs
        for (int md = 0; md < 4; md++) begin
            for (int sg = 0; sg < 2; sg++) begin
                send(2'b01, sg[0], 3, 32'h8000_0080, 0, md[1:0], 0, "R5");
                send(2'b01, sg[0], 3, 32'h8000_0180, 0, md[1:0], 0, "R5");
                send(2'b01, sg[0], 3, 32'h8000_0040, 0, md[1:0], 0, "R5");
                send(2'b01, sg[0], 3, 32'h8000_0100, 1, md[1:0], 0, "R5");
                send(2'b01, sg[0], 3, 32'h8000_00C1, 0, md[1:0], 0, "R5");
            end
        end

        // R6 carry into exponent
        send(2'b01, 0, 10, 32'hFFFF_FF80, 0, 2'b00, 0, "R6");
        send(2'b01, 1, -20, 32'hFFFF_FF01, 0, 2'b11, 0, "R6");

        // R7 subnormals, exact and inexact
        send(2'b01, 0, -127, 32'h8000_0000, 0, 2'b00, 0, "R7");
        send(2'b01, 1, -130, 32'hC000_0000, 0, 2'b01, 0, "R7");
        send(2'b01, 0, -149, 32'h8000_0000, 0, 2'b00, 0, "R7");

        // R8 largest subnormal promoted to smallest normal
        send(2'b01, 0, -127, 32'hFFFF_FFC0, 0, 2'b00, 0, "R8");
        send(2'b01, 1, -127, 32'hFFFF_FE01, 0, 2'b11, 1, "R8");

        // R9 underflow from inexact and from the trap enable
        send(2'b01, 0, -135, 32'h8000_0001, 0, 2'b01, 0, "R9");
        send(2'b01, 0, -130, 32'h8000_0000, 0, 2'b00, 1, "R9");
        send(2'b01, 0, -130, 32'h8000_0000, 0, 2'b00, 0, "R9");
        send(2'b01, 0, -400, 32'h8000_0000, 0, 2'b10, 0, "R9");
        send(2'b01, 1, -400, 32'h8000_0000, 0, 2'b10, 0, "R9");

        // R10 overflow in every mode and sign, direct and via carry
        for (int md = 0; md < 4; md++) begin
            for (int sg = 0; sg < 2; sg++) begin
                send(2'b01, sg[0], 128, 32'h8000_0000, 0, md[1:0], 0, "R10");
                send(2'b01, sg[0], 127, 32'hFFFF_FFFF, 0, md[1:0], 0, "R10");
                send(2'b01, sg[0], 300, 32'h9000_0000, 0, md[1:0], 0, "R10");
            end
        end

        // R5 sweep over exponents, mantissas and modes
        for (int k = 0; k < 300; k++) begin
            send(2'b01, 1'($urandom), int'($urandom_range(0, 310)) - 165,
                 $urandom | 32'h8000_0000, 1'($urandom), 2'($urandom), 1'($urandom), "R5");
        end

        @(negedge clk); in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R11", "results outstanding", 35'(sb_q.size()), 35'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule